// File: doc/BRIEF.md
# Peripheral Interrupt Controller with Vectoring

This controller gathers 28 single-cycle interrupt pulses from on-chip peripherals into a sticky pending register. It gates them through a per-source enable mask and raises one request toward the processor bus at a software-chosen level from 1 to 7. Among the enabled pending sources it picks a winner. Sources 0 to 3 are the four serial channels, whose internal order can be rotated. Any single source may also be promoted above all others.

When the bus runs an acknowledge at the programmed level, the controller enters an ID arbitration with fixed ID 8 against the other requesters at that level. If it wins, it returns an 8-bit vector. The top three bits are a programmable base. The low five bits give the winning source number plus one, and zero marks a spurious acknowledge. Software reaches three registers through a plain write/read port.

The acknowledge follows a valid/ready pattern. The bus holds `iack_valid_i` high for the whole acknowledge cycle. The controller answers with `vec_valid_o` once it has won, and holds `vec_o` unchanged until the bus lowers `iack_valid_i`. The bus may stretch the cycle for as long as it needs to take the vector, which is its form of back-pressure. The controller drops `vec_valid_o` one clock after `iack_valid_i` falls.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A pulse on `src_pulse_i[k]` sets pending bit k, which stays set until software writes 1 to bit k at address 0. A pulse in the same cycle as that clear leaves the bit set.
- R2: `irq_level_o` equals the level field (config bits [2:0]) while any pending bit is also set in the mask register (address 1, 1 = enabled). Otherwise it is 0.
- R3: By default, any enabled serial source (0–3) outranks sources 4–27. Among sources 4–27, the lower number wins.
- R4: With the rotation field r (config bits [13:12]), the serial order is r, r+1, r+2, r+3, taken modulo 4.
- R5: With promotion enabled (config bit 11), the source named in config bits [10:6] outranks every other source whenever it is enabled and pending.
- R6: The controller takes part in an acknowledge only when `iack_level_i` equals a nonzero programmed level. On any other acknowledge it raises neither `arb_drive_o` nor `vec_valid_o`.
- R7: On a matching acknowledge it presents ID 8 on `arb_id_o` with `arb_drive_o` high in the first cycle. It wins unless a peer is valid with an ID above 7. After a loss it drives no vector and keeps its request raised.
- R8: The vector is {base (config bits [5:3]), source number + 1}. With no enabled source pending, the low five bits are 0.
- R9: The vector is taken in the first acknowledge cycle and stays valid and unchanged while `iack_valid_i` stays high, even if new sources become pending. `vec_valid_o` falls one clock after `iack_valid_i` falls.
- R10: Reading address 0, 1 or 2 returns the pending, mask or config register, zero-extended.
- R11: After reset, pending, mask and config are all zero, no request is raised and no vector is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse_i | input | 28 | One-cycle event pulses from the sources |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 pending, 1 mask, 2 config) |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational) |
| irq_level_o | output | 3 | Request level toward the bus, 0 when idle |
| iack_valid_i | input | 1 | Acknowledge cycle in progress |
| iack_level_i | input | 3 | Level being acknowledged |
| arb_peer_valid_i | input | 1 | Another requester is arbitrating |
| arb_peer_id_i | input | 4 | Highest ID among the other requesters |
| arb_drive_o | output | 1 | Controller presents its ID this cycle |
| arb_id_o | output | 4 | Controller ID (8) while presenting, else 0 |
| vec_valid_o | output | 1 | Vector is being supplied |
| vec_o | output | 8 | Interrupt vector |

## Verification
On every cycle, the assertions check four rules: pending bits never miss a pulse, a nonzero request always has an enabled pending source behind it, a supplied vector stays frozen while it is valid, and a vector only appears after an acknowledge at the programmed level that the arbitration allowed. The priority rules cannot be shown that way. These are the default order, serial rotation, promotion, the exact vector encodings including the spurious code, and the readback and clear-versus-set cases. Only the bench's scenarios show them, by comparing the vectors produced for chosen pending patterns.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int IDX_W  = 5;
  localparam int ROT_W  = 2;
  localparam int LVL_W  = 3;
  localparam int ARB_W  = 4;
  localparam int VEC_W  = 8;
  localparam int BASE_W = VEC_W - IDX_W;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 2;

  typedef struct packed {
    logic [ROT_W-1:0]  ser_rot;
    logic              promo_en;
    logic [IDX_W-1:0]  promo_idx;
    logic [BASE_W-1:0] base;
    logic [LVL_W-1:0]  level;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic [ADDR_W-1:0] {
    REG_PEND = 2'd0,
    REG_MASK = 2'd1,
    REG_CFG  = 2'd2
  } reg_addr_e;

  typedef enum logic [1:0] {
    ACK_IDLE,
    ACK_SERVE,
    ACK_SKIP
  } ack_state_e;
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs
  import irqv_pkg::*;
#(
  parameter int N_SRC = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_SRC-1:0]    src_pulse_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  output logic [N_SRC-1:0]    pend_o,
  output logic [N_SRC-1:0]    mask_o,
  output cfg_t                cfg_o
);
  logic [N_SRC-1:0] pend_q, mask_q, clr;
  cfg_t             cfg_q;
  logic             unused_hi;

  assign unused_hi = ^wdata_i[REG_W-1:N_SRC];
  assign clr = (wr_en_i && addr_i == REG_PEND) ? wdata_i[N_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      cfg_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | src_pulse_i;
      if (wr_en_i && addr_i == REG_MASK) mask_q <= wdata_i[N_SRC-1:0];
      if (wr_en_i && addr_i == REG_CFG)  cfg_q  <= cfg_t'(wdata_i[CFG_W-1:0]);
    end
  end

  always_comb begin
    case (addr_i)
      REG_PEND: rdata_o = REG_W'(pend_q);
      REG_MASK: rdata_o = REG_W'(mask_q);
      REG_CFG:  rdata_o = REG_W'(cfg_q);
      default:  rdata_o = '0;
    endcase
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign cfg_o  = cfg_q;
endmodule

// File: rtl/irqv_select.sv
module irqv_select
  import irqv_pkg::*;
#(
  parameter int N_SRC = 28,
  parameter int N_SER = 4
) (
  input  logic [N_SRC-1:0] elig_i,
  input  logic [ROT_W-1:0] rot_i,
  input  logic             promo_en_i,
  input  logic [IDX_W-1:0] promo_idx_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             ser_found, oth_found, promo_hit;
  logic [IDX_W-1:0] ser_idx, oth_idx;

  // Serial group: walk the rotated order backwards so the first hit wins.
  always_comb begin
    ser_found = 1'b0;
    ser_idx   = '0;
    for (int k = N_SER - 1; k >= 0; k--) begin
      int pos;
      pos = (int'(rot_i) + k) % N_SER;
      if (elig_i[pos]) begin
        ser_found = 1'b1;
        ser_idx   = IDX_W'(pos);
      end
    end
  end

  always_comb begin
    oth_found = 1'b0;
    oth_idx   = '0;
    for (int i = N_SRC - 1; i >= N_SER; i--) begin
      if (elig_i[i]) begin
        oth_found = 1'b1;
        oth_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    promo_hit = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      if (promo_idx_i == IDX_W'(i)) promo_hit = promo_en_i & elig_i[i];
  end

  always_comb begin
    if (promo_hit)      idx_o = promo_idx_i;
    else if (ser_found) idx_o = ser_idx;
    else                idx_o = oth_idx;
  end

  assign found_o = ser_found | oth_found;
endmodule

// File: rtl/irqv_ack.sv
module irqv_ack
  import irqv_pkg::*;
#(
  parameter int ARB_ID = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iack_valid_i,
  input  logic [LVL_W-1:0]  iack_level_i,
  input  logic              peer_valid_i,
  input  logic [ARB_W-1:0]  peer_id_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              found_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              arb_drive_o,
  output logic [ARB_W-1:0]  arb_id_o,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_o
);
  ack_state_e       state_q;
  logic [VEC_W-1:0] vec_q;
  logic             match, win;
  logic [IDX_W-1:0] low_code;

  assign match    = iack_valid_i && (level_i != '0) && (iack_level_i == level_i);
  assign win      = !peer_valid_i || (peer_id_i < ARB_W'(ARB_ID));
  assign low_code = found_i ? idx_i + IDX_W'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACK_IDLE;
      vec_q   <= '0;
    end else begin
      case (state_q)
        ACK_IDLE: if (iack_valid_i) begin
          if (match && win) begin
            state_q <= ACK_SERVE;
            vec_q   <= {base_i, low_code};
          end else begin
            state_q <= ACK_SKIP;
          end
        end
        default: if (!iack_valid_i) state_q <= ACK_IDLE;
      endcase
    end
  end

  assign arb_drive_o = (state_q == ACK_IDLE) && match;
  assign arb_id_o    = arb_drive_o ? ARB_W'(ARB_ID) : '0;
  assign vec_valid_o = (state_q == ACK_SERVE);
  assign vec_o       = vec_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int N_SRC  = 28,
  parameter int N_SER  = 4,
  parameter int ARB_ID = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   src_pulse_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic [LVL_W-1:0]   irq_level_o,
  input  logic               iack_valid_i,
  input  logic [LVL_W-1:0]   iack_level_i,
  input  logic               arb_peer_valid_i,
  input  logic [ARB_W-1:0]   arb_peer_id_i,
  output logic               arb_drive_o,
  output logic [ARB_W-1:0]   arb_id_o,
  output logic               vec_valid_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic [N_SRC-1:0] pend_q, mask_q, elig;
  cfg_t             cfg_q;
  logic             sel_found;
  logic [IDX_W-1:0] sel_idx;
  logic [LVL_W-1:0] cfg_level;

  irqv_regs #(.N_SRC(N_SRC)) i_regs (
    .clk(clk), .rst_n(rst_n), .src_pulse_i(src_pulse_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pend_o(pend_q), .mask_o(mask_q), .cfg_o(cfg_q)
  );

  assign elig      = pend_q & mask_q;
  assign cfg_level = cfg_q.level;

  irqv_select #(.N_SRC(N_SRC), .N_SER(N_SER)) i_select (
    .elig_i(elig), .rot_i(cfg_q.ser_rot), .promo_en_i(cfg_q.promo_en),
    .promo_idx_i(cfg_q.promo_idx), .found_o(sel_found), .idx_o(sel_idx)
  );

  irqv_ack #(.ARB_ID(ARB_ID)) i_ack (
    .clk(clk), .rst_n(rst_n), .iack_valid_i(iack_valid_i),
    .iack_level_i(iack_level_i), .peer_valid_i(arb_peer_valid_i),
    .peer_id_i(arb_peer_id_i), .level_i(cfg_q.level), .base_i(cfg_q.base),
    .found_i(sel_found), .idx_i(sel_idx), .arb_drive_o(arb_drive_o),
    .arb_id_o(arb_id_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o)
  );

  assign irq_level_o = (|elig) ? cfg_q.level : '0;
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
  import irqv_pkg::*;
#(
  parameter int N_SRC  = 28,
  parameter int ARB_ID = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  src_pulse_i,
  input logic [N_SRC-1:0]  pend,
  input logic [N_SRC-1:0]  mask,
  input logic [LVL_W-1:0]  cfg_level,
  input logic [LVL_W-1:0]  irq_level_o,
  input logic              iack_valid_i,
  input logic [LVL_W-1:0]  iack_level_i,
  input logic              arb_peer_valid_i,
  input logic [ARB_W-1:0]  arb_peer_id_i,
  input logic              vec_valid_o,
  input logic [VEC_W-1:0]  vec_o
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  assert_pulse_latched_R1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(src_pulse_i) & ~pend) == '0));

  assert_request_backed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level_o != '0) |-> (((pend & mask) != '0) && (irq_level_o == cfg_level)));

  assert_level_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(vec_valid_o)) |->
      ($past(iack_valid_i) && $past(iack_level_i) == cfg_level && cfg_level != '0));

  assert_arb_won_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(vec_valid_o)) |->
      (!$past(arb_peer_valid_i) || $past(arb_peer_id_i) < ARB_W'(ARB_ID)));

  assert_vector_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && vec_valid_o && $past(vec_valid_o)) |-> $stable(vec_o));

  assert_vector_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && vec_valid_o) |-> $past(iack_valid_i));
endmodule

bind irq_vector_ctrl irqv_checker #(.N_SRC(N_SRC), .ARB_ID(ARB_ID)) i_checker (
  .clk(clk), .rst_n(rst_n), .src_pulse_i(src_pulse_i), .pend(pend_q),
  .mask(mask_q), .cfg_level(cfg_level), .irq_level_o(irq_level_o),
  .iack_valid_i(iack_valid_i), .iack_level_i(iack_level_i),
  .arb_peer_valid_i(arb_peer_valid_i), .arb_peer_id_i(arb_peer_id_i),
  .vec_valid_o(vec_valid_o), .vec_o(vec_o)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] src_pulse = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq_level;
  logic        iack_valid = 1'b0;
  logic [2:0]  iack_level = '0;
  logic        peer_valid = 1'b0;
  logic [3:0]  peer_id = '0;
  logic        arb_drive;
  logic [3:0]  arb_id;
  logic        vec_valid;
  logic [7:0]  vec;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // base 5, level 5 -> vector top bits 3'b101
  localparam logic [31:0] CFG_BASE = 32'h2D;

  always #2.5 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .src_pulse_i(src_pulse), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_level_o(irq_level),
    .iack_valid_i(iack_valid), .iack_level_i(iack_level),
    .arb_peer_valid_i(peer_valid), .arb_peer_id_i(peer_id),
    .arb_drive_o(arb_drive), .arb_id_o(arb_id),
    .vec_valid_o(vec_valid), .vec_o(vec)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input logic [27:0] m);
    @(negedge clk); src_pulse = m;
    @(negedge clk); src_pulse = '0;
  endtask

  task automatic do_ack(input logic [2:0] lvl, input logic pv, input logic [3:0] pid,
                        output logic drv, output logic [3:0] aid,
                        output logic vv, output logic [7:0] v);
    @(negedge clk); iack_valid = 1'b1; iack_level = lvl; peer_valid = pv; peer_id = pid;
    #1; drv = arb_drive; aid = arb_id;
    @(negedge clk); vv = vec_valid; v = vec;
    iack_valid = 1'b0; peer_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack_expect(input logic [7:0] exp_vec, input string req);
    logic drv, vv; logic [3:0] aid; logic [7:0] v;
    do_ack(3'd5, 1'b0, 4'd0, drv, aid, vv, v);
    check(vv == 1'b1 && v == exp_vec, req, {23'd0, vv, v}, {24'd1, exp_vec});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(irq_level == 3'd0, "R11 no request", 32'(irq_level), 0);
    check(vec_valid == 1'b0, "R11 no vector", 32'(vec_valid), 0);
    reg_read(2'd0, d); check(d == 0, "R11 pending zero", d, 0);
    reg_read(2'd2, d); check(d == 0, "R11 config zero", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    reg_write(2'd1, 32'hFFFF_FFFF);
    reg_read(2'd1, d); check(d == 32'h0FFF_FFFF, "R10 mask readback", d, 32'h0FFF_FFFF);
    reg_write(2'd2, CFG_BASE);
    reg_read(2'd2, d); check(d == CFG_BASE, "R10 config readback", d, CFG_BASE);
    reg_read(2'd3, d); check(d == 0, "R10 unused address", d, 0);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    pulse(28'h80);
    reg_read(2'd0, d); check(d == 32'h80, "R1 pulse latched", d, 32'h80);
    repeat (3) @(negedge clk);
    reg_read(2'd0, d); check(d == 32'h80, "R1 bit held", d, 32'h80);
    check(irq_level == 3'd5, "R2 request at level", 32'(irq_level), 5);
    reg_write(2'd0, 32'h80);
    reg_read(2'd0, d); check(d == 0, "R1 write-one clear", d, 0);
    check(irq_level == 3'd0, "R2 request drops", 32'(irq_level), 0);
    @(negedge clk); src_pulse = 28'h200; wr_en = 1'b1; addr = 2'd0; wdata = 32'h200;
    @(negedge clk); src_pulse = '0; wr_en = 1'b0; wdata = '0;
    reg_read(2'd0, d); check(d == 32'h200, "R1 pulse beats clear", d, 32'h200);
    reg_write(2'd0, 32'h0FFF_FFFF);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    reg_write(2'd1, 32'h0);
    pulse(28'h8);
    reg_read(2'd0, d); check(d == 32'h8, "R2 masked still pending", d, 32'h8);
    check(irq_level == 3'd0, "R2 masked no request", 32'(irq_level), 0);
    reg_write(2'd1, 32'h8);
    check(irq_level == 3'd5, "R2 unmasked request", 32'(irq_level), 5);
    reg_write(2'd1, 32'h0FFF_FFFF);
    reg_write(2'd0, 32'h0FFF_FFFF);
  endtask

  task automatic t_default_order();
    pulse(28'h0100440);                 // sources 6, 10, 20
    ack_expect(8'hA7, "R3 lowest non-serial wins");
    pulse(28'h4);                       // serial source 2 joins
    ack_expect(8'hA3, "R3 serial outranks others");
    reg_write(2'd0, 32'h0FFF_FFFF);
  endtask

  task automatic t_rotation();
    pulse(28'h9);                       // serial 0 and 3
    ack_expect(8'hA1, "R4 rotation 0 picks 0");
    reg_write(2'd2, CFG_BASE | (32'd1 << 12));
    ack_expect(8'hA4, "R4 rotation 1 picks 3");
    reg_write(2'd2, CFG_BASE | (32'd3 << 12));
    ack_expect(8'hA4, "R4 rotation 3 picks 3");
    reg_write(2'd2, CFG_BASE);
    reg_write(2'd0, 32'h0FFF_FFFF);
  endtask

  task automatic t_promote();
    reg_write(2'd2, CFG_BASE | (32'd1 << 11) | (32'd25 << 6));
    pulse(28'h2000001);                 // sources 0 and 25
    ack_expect(8'hBA, "R5 promoted source wins");
    reg_write(2'd0, 32'h2000000);
    ack_expect(8'hA1, "R5 fallback when promoted idle");
    reg_write(2'd2, CFG_BASE);
    reg_write(2'd0, 32'h0FFF_FFFF);
  endtask

  task automatic t_level_arb();
    logic drv, vv; logic [3:0] aid; logic [7:0] v;
    pulse(28'h10);                      // source 4
    do_ack(3'd3, 1'b0, 4'd0, drv, aid, vv, v);
    check(drv == 1'b0 && vv == 1'b0, "R6 other level ignored", {30'd0, drv, vv}, 0);
    do_ack(3'd5, 1'b1, 4'd12, drv, aid, vv, v);
    check(drv == 1'b1 && aid == 4'd8, "R7 presents ID 8", {27'd0, drv, aid}, 32'h18);
    check(vv == 1'b0, "R7 lost no vector", 32'(vv), 0);
    check(irq_level == 3'd5, "R7 request kept after loss", 32'(irq_level), 5);
    do_ack(3'd5, 1'b1, 4'd3, drv, aid, vv, v);
    check(vv == 1'b1 && v == 8'hA5, "R7 wins over lower peer", {23'd0, vv, v}, 32'h1A5);
    reg_write(2'd0, 32'h0FFF_FFFF);
  endtask

  task automatic t_spurious();
    ack_expect(8'hA0, "R8 spurious code");
  endtask

  task automatic t_hold();
    pulse(28'h400);                     // source 10
    @(negedge clk); iack_valid = 1'b1; iack_level = 3'd5;
    @(negedge clk);
    check(vec_valid && vec == 8'hAB, "R9 first vector", {23'd0, vec_valid, vec}, 32'h1AB);
    src_pulse = 28'h2;                  // higher source during the cycle
    @(negedge clk); src_pulse = '0;
    check(vec_valid && vec == 8'hAB, "R9 vector frozen", {23'd0, vec_valid, vec}, 32'h1AB);
    @(negedge clk);
    check(vec_valid && vec == 8'hAB, "R9 still frozen", {23'd0, vec_valid, vec}, 32'h1AB);
    iack_valid = 1'b0;
    @(negedge clk);
    check(vec_valid == 1'b0, "R9 valid drops", 32'(vec_valid), 0);
    ack_expect(8'hA2, "R9 new source seen next cycle");
    reg_write(2'd0, 32'h0FFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_regs();
    t_pending();
    t_mask();
    t_default_order();
    t_rotation();
    t_promote();
    t_level_arb();
    t_spurious();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule